// File: doc/BRIEF.md
# Unrolled Interval Renormalizer for a Binary Arithmetic Encoder

This unit takes the place of the shift-one-bit-per-iteration renormalization loop of an integer arithmetic encoder. Each accepted update presents the freshly narrowed 16-bit interval bounds, low and high. In a single pass the unit finds the leading bits on which both bounds already agree and counts the underflow run that follows them. It then produces, one cycle later, the full set of bits that the loop would have written, the number of those bits, the renormalized bounds, and the updated count of deferred (pending) bits.

The shared prefix comes from an XOR of the bounds feeding a leading-zero count. The underflow run is found by a bank of parallel run detectors, one for each prefix length that can leave room for a run. The prefix length selects which detector applies. Emitted bits are MSB-aligned in a wide output field: the first settled bit, then the deferred bits with the opposite value, then the rest of the settled bits. The deferred count lives in a register inside the unit and is visible at a port. Packing of bits into bytes and probability modelling are handled elsewhere.

Top module: `cbd_renorm`

## Requirements
- R1: While rst_ni is low and until the first accepted update, valid_o is 0, low_o is 0, high_o is all ones, follow_o is 0 and bits_cnt_o is 0.
- R2: An update presented with valid_i high at a rising clock edge appears at the outputs on that edge, and valid_o is high for exactly the cycles after an accepted update. Without valid_i the outputs and the pending count hold their values.
- R3: Let k be the number of leading bit positions where low_i equals high_i (0 to 16) and P the pending count before the update. bits_cnt_o is k+P when k>0, and 0 when k=0.
- R4: bits_o is MSB-aligned. Its top bit is low_i[15]. The next P bits are the complement of that bit. The next k-1 bits are low_i[14] downward. All bits below bits_cnt_o are 0.
- R5: The run length m counts the positions directly below the first differing bit where low_i holds 1 and high_i holds 0. low_o is low_i shifted left by k+m with zeros filled in. high_o is high_i shifted left by k+m with ones filled in.
- R6: When m>0, the top bit of low_o is forced to 0 and the top bit of high_o to 1 after the shift.
- R7: The new pending count is m when k>0 and P+m when k=0. It is visible on follow_o after the update.
- R8: When low_i equals high_i, all 16 bits are emitted (plus any pending bits), low_o becomes 0 and high_o becomes all ones.
- R9: For any input pair with low_i <= high_i, the outputs match those of the sequential loop that emits, defers and doubles one bit at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Update present this cycle |
| low_i | input | 16 | Narrowed lower bound |
| high_i | input | 16 | Narrowed upper bound, not below low_i |
| valid_o | output | 1 | Result registered from an update |
| bits_o | output | 47 | Emitted bits, MSB-aligned |
| bits_cnt_o | output | 6 | Number of valid bits in bits_o from the MSB |
| low_o | output | 16 | Renormalized lower bound |
| high_o | output | 16 | Renormalized upper bound |
| follow_o | output | 5 | Pending deferred-bit count |

## Verification
The hardest state to reach is a large pending count that is flushed behind a settled bit. The flush needs several updates in a row that share no leading bit but carry an underflow run, followed by one that settles a bit. Random bounds almost never line up like that. The stimulus therefore builds each pair from a chosen prefix length and run length: a random prefix, the 0/1 split, a run of 1-over-0 bits, and a random tail. Directed sequences also stack deferred bits up to a 15-long run before flushing them. Every result is compared against a bit-serial loop model in the bench.

// File: rtl/cbd_pkg.sv
package cbd_pkg;
  localparam int unsigned DEF_W      = 16;
  localparam int unsigned DEF_PEND_W = 5;

  function automatic int unsigned out_width(input int unsigned w, input int unsigned pw);
    return w + (1 << pw) - 1;
  endfunction
endpackage

// File: rtl/cbd_lzd.sv
module cbd_lzd #(
  parameter int unsigned W     = 16,
  parameter int unsigned CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     diff_i,
  output logic [CNT_W-1:0] lead_o
);
  logic found;
  always_comb begin
    lead_o = CNT_W'(W);
    found  = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!found && diff_i[i]) begin
        lead_o = CNT_W'(W - 1 - i);
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cbd_follow_bank.sv
module cbd_follow_bank #(
  parameter int unsigned W     = 16,
  parameter int unsigned CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     low_i,
  input  logic [W-1:0]     high_i,
  input  logic [CNT_W-1:0] lead_i,
  output logic [CNT_W-1:0] run_o
);
  localparam int unsigned NSEL = 1 << CNT_W;

  logic [CNT_W-1:0] run_tab [NSEL];

  for (genvar g = 0; g < NSEL; g++) begin : g_run
    if (g < W - 1) begin : g_live
      logic [CNT_W-1:0] run;
      logic             live;
      // run starts just below the first differing bit (position W-1-g)
      always_comb begin
        run  = '0;
        live = 1'b1;
        for (int b = W - 2 - g; b >= 0; b--) begin
          if (live && low_i[b] && !high_i[b]) run = run + CNT_W'(1);
          else live = 1'b0;
        end
      end
      assign run_tab[g] = run;
    end else begin : g_none
      assign run_tab[g] = '0;
    end
  end

  assign run_o = run_tab[lead_i];
endmodule

// File: rtl/cbd_emit.sv
module cbd_emit #(
  parameter int unsigned W      = 16,
  parameter int unsigned CNT_W  = $clog2(W + 1),
  parameter int unsigned PEND_W = 5,
  parameter int unsigned OUT_W  = W + (1 << PEND_W) - 1,
  parameter int unsigned OCNT_W = $clog2(OUT_W + 1)
) (
  input  logic [W-1:0]      low_i,
  input  logic [CNT_W-1:0]  lead_i,
  input  logic [PEND_W-1:0] pend_i,
  output logic [OUT_W-1:0]  bits_o,
  output logic [OCNT_W-1:0] cnt_o
);
  logic first_bit;
  int   np;
  int   nk;

  always_comb begin
    bits_o    = '0;
    cnt_o     = '0;
    first_bit = low_i[W-1];
    np        = int'(pend_i);
    nk        = int'(lead_i);
    if (lead_i != '0) begin
      cnt_o = OCNT_W'(lead_i) + OCNT_W'(pend_i);
      for (int j = 0; j < OUT_W; j++) begin
        if (j == 0)                bits_o[OUT_W-1-j] = first_bit;
        else if (j <= np)          bits_o[OUT_W-1-j] = ~first_bit;
        else if (j < np + nk)      bits_o[OUT_W-1-j] = low_i[W-1-(j-np)];
      end
    end
  end
endmodule

// File: rtl/cbd_renorm.sv
module cbd_renorm
  import cbd_pkg::*;
#(
  parameter int unsigned W      = DEF_W,
  parameter int unsigned PEND_W = DEF_PEND_W,
  localparam int unsigned CNT_W  = $clog2(W + 1),
  localparam int unsigned OUT_W  = out_width(W, PEND_W),
  localparam int unsigned OCNT_W = $clog2(OUT_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [W-1:0]      low_i,
  input  logic [W-1:0]      high_i,
  output logic              valid_o,
  output logic [OUT_W-1:0]  bits_o,
  output logic [OCNT_W-1:0] bits_cnt_o,
  output logic [W-1:0]      low_o,
  output logic [W-1:0]      high_o,
  output logic [PEND_W-1:0] follow_o
);
  localparam logic [W-1:0] ONES = '1;

  logic [CNT_W-1:0]  lead;
  logic [CNT_W-1:0]  run;
  logic [CNT_W-1:0]  shamt;
  logic [W-1:0]      low_n;
  logic [W-1:0]      high_n;
  logic [PEND_W-1:0] pend_n;
  logic [OUT_W-1:0]  bits_n;
  logic [OCNT_W-1:0] cnt_n;

  cbd_lzd #(.W(W), .CNT_W(CNT_W)) u_lzd (
    .diff_i (low_i ^ high_i),
    .lead_o (lead)
  );

  cbd_follow_bank #(.W(W), .CNT_W(CNT_W)) u_bank (
    .low_i  (low_i),
    .high_i (high_i),
    .lead_i (lead),
    .run_o  (run)
  );

  cbd_emit #(.W(W), .CNT_W(CNT_W), .PEND_W(PEND_W), .OUT_W(OUT_W), .OCNT_W(OCNT_W)) u_emit (
    .low_i  (low_i),
    .lead_i (lead),
    .pend_i (follow_o),
    .bits_o (bits_n),
    .cnt_o  (cnt_n)
  );

  assign shamt = lead + run;

  always_comb begin
    low_n  = low_i << shamt;
    high_n = (high_i << shamt) | ~(ONES << shamt);
    if (run != '0) begin
      low_n[W-1]  = 1'b0;
      high_n[W-1] = 1'b1;
    end
    pend_n = (lead != '0) ? PEND_W'(run) : follow_o + PEND_W'(run);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      bits_o     <= '0;
      bits_cnt_o <= '0;
      low_o      <= '0;
      high_o     <= ONES;
      follow_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        bits_o     <= bits_n;
        bits_cnt_o <= cnt_n;
        low_o      <= low_n;
        high_o     <= high_n;
        follow_o   <= pend_n;
      end
    end
  end
endmodule

// File: rtl/cbd_renorm_chk.sv
module cbd_renorm_chk #(
  parameter int unsigned W      = 16,
  parameter int unsigned PEND_W = 5,
  parameter int unsigned OCNT_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [W-1:0]      low_i,
  input logic [W-1:0]      high_i,
  input logic              valid_o,
  input logic [OCNT_W-1:0] bits_cnt_o,
  input logic [W-1:0]      low_o,
  input logic [W-1:0]      high_o,
  input logic [PEND_W-1:0] follow_o
);
  AST_IN_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> low_i <= high_i); // R9
  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R2
  AST_VALID_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R2
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(low_o) && $stable(high_o) && $stable(follow_o) && $stable(bits_cnt_o)); // R2
  AST_NORMALIZED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !low_o[W-1] && high_o[W-1] && !(low_o[W-2] && !high_o[W-2])); // R5
  AST_PEND_GROWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && bits_cnt_o == '0) |-> follow_o >= $past(follow_o)); // R7
endmodule

bind cbd_renorm cbd_renorm_chk #(.W(W), .PEND_W(PEND_W), .OCNT_W(OCNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .low_i      (low_i),
  .high_i     (high_i),
  .valid_o    (valid_o),
  .bits_cnt_o (bits_cnt_o),
  .low_o      (low_o),
  .high_o     (high_o),
  .follow_o   (follow_o)
);

// File: tb/cbd_renorm_tb_top.sv
module cbd_renorm_tb_top;
  localparam int unsigned W      = 16;
  localparam int unsigned OUT_W  = 47;
  localparam time         CLK_PERIOD = 10ns;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              valid_i = 1'b0;
  logic [W-1:0]      low_i = '0;
  logic [W-1:0]      high_i = '0;
  logic              valid_o;
  logic [OUT_W-1:0]  bits_o;
  logic [5:0]        bits_cnt_o;
  logic [W-1:0]      low_o;
  logic [W-1:0]      high_o;
  logic [4:0]        follow_o;

  int n_chk  = 0;
  int n_fail = 0;
  int ref_pend = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cbd_renorm dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .low_i(low_i), .high_i(high_i),
    .valid_o(valid_o), .bits_o(bits_o), .bits_cnt_o(bits_cnt_o),
    .low_o(low_o), .high_o(high_o), .follow_o(follow_o)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bit-serial loop model
  task automatic ref_loop(input int lo_in, input int hi_in, output logic [63:0] acc,
                          output int n, output int lo, output int hi);
    logic done;
    lo = lo_in; hi = hi_in; acc = '0; n = 0; done = 1'b0;
    while (!done) begin
      if (hi < 'h8000 || lo >= 'h8000) begin
        logic b;
        b = (lo >= 'h8000);
        acc[63-n] = b; n++;
        for (int i = 0; i < ref_pend; i++) begin acc[63-n] = ~b; n++; end
        ref_pend = 0;
        if (b) begin lo -= 'h8000; hi -= 'h8000; end
      end else if (lo >= 'h4000 && hi < 'hC000) begin
        ref_pend++; lo -= 'h4000; hi -= 'h4000;
      end else begin
        done = 1'b1;
      end
      if (!done) begin lo = 2 * lo; hi = 2 * hi + 1; end
    end
  endtask

  task automatic apply(input logic [W-1:0] lo_v, input logic [W-1:0] hi_v, input string req);
    logic [63:0] acc; int n, lo, hi;
    ref_loop(int'(lo_v), int'(hi_v), acc, n, lo, hi);
    low_i = lo_v; high_i = hi_v; valid_i = 1'b1;
    @(negedge clk);
    chk(req, "valid_o", 64'(valid_o), 64'd1);
    chk(req, "bits_cnt_o", 64'(bits_cnt_o), 64'(n));
    chk(req, "bits_o", 64'(bits_o), 64'(acc[63 -: OUT_W]));
    chk(req, "low_o", 64'(low_o), 64'(lo));
    chk(req, "high_o", 64'(high_o), 64'(hi));
    chk(req, "follow_o", 64'(follow_o), 64'(ref_pend));
  endtask

  function automatic logic [2*W-1:0] make_pair(input int k, input int m);
    logic [W-1:0] lo, hi, p;
    int pos;
    p = W'($urandom); lo = '0; hi = '0; pos = W - 1;
    for (int i = 0; i < k && pos >= 0; i++) begin lo[pos] = p[i]; hi[pos] = p[i]; pos--; end
    if (pos >= 0) begin lo[pos] = 1'b0; hi[pos] = 1'b1; pos--; end
    for (int j = 0; j < m && pos >= 0; j++) begin lo[pos] = 1'b1; hi[pos] = 1'b0; pos--; end
    while (pos >= 0) begin lo[pos] = 1'($urandom); hi[pos] = 1'($urandom); pos--; end
    return {lo, hi};
  endfunction

  task automatic t_reset;
    chk("R1", "valid_o", 64'(valid_o), 64'd0);
    chk("R1", "low_o", 64'(low_o), 64'd0);
    chk("R1", "high_o", 64'(high_o), 64'hFFFF);
    chk("R1", "follow_o", 64'(follow_o), 64'd0);
    chk("R1", "bits_cnt_o", 64'(bits_cnt_o), 64'd0);
  endtask

  task automatic t_prefix;
    apply(16'hA000, 16'hA7FF, "R3");
    chk("R4", "bits_o top", 64'(bits_o[OUT_W-1 -: 5]), 64'b10100);
    apply(16'h1234, 16'hF000, "R5");
    chk("R3", "no common bits", 64'(bits_cnt_o), 64'd0);
  endtask

  task automatic t_hold;
    logic [W-1:0] l0, h0;
    apply(16'h2100, 16'h2FFF, "R2");
    l0 = low_o; h0 = high_o;
    valid_i = 1'b0; low_i = 16'h0001; high_i = 16'hFFFE;
    @(negedge clk); @(negedge clk);
    chk("R2", "valid_o idle", 64'(valid_o), 64'd0);
    chk("R2", "low_o held", 64'(low_o), 64'(l0));
    chk("R2", "high_o held", 64'(high_o), 64'(h0));
  endtask

  task automatic t_follow_flush;
    apply(16'h4000, 16'hBFFF, "R7");
    apply(16'h4000, 16'hBFFF, "R7");
    chk("R7", "pending accumulates", 64'(follow_o), 64'd2);
    apply(16'h0000, 16'h3FFF, "R4");
    chk("R4", "flushed pattern", 64'(bits_o[OUT_W-1 -: 4]), 64'b0110);
    chk("R7", "pending cleared", 64'(follow_o), 64'd0);
  endtask

  task automatic t_long_run;
    apply(16'h7FFF, 16'h8000, "R6");
    chk("R6", "low_o top cleared", 64'(low_o), 64'h0000);
    chk("R6", "high_o top set", 64'(high_o), 64'hFFFF);
    apply(16'hC000, 16'hC001, "R6");
  endtask

  task automatic t_equal;
    apply(16'h5A5A, 16'h5A5A, "R8");
    chk("R8", "all bits", 64'(bits_cnt_o), 64'd16);
    chk("R8", "low_o", 64'(low_o), 64'd0);
  endtask

  task automatic t_random;
    for (int it = 0; it < 3000; it++) begin
      logic [2*W-1:0] pr;
      logic [W-1:0] a, b;
      int k;
      k = (ref_pend > 14) ? 1 + int'($urandom % 16) : int'($urandom % 17);
      if (ref_pend <= 14 && ($urandom % 4) == 0) begin
        a = W'($urandom); b = W'($urandom);
        if (a > b) pr = {b, a}; else pr = {a, b};
        if (ref_pend > 14) pr = make_pair(k, 0);
      end else begin
        pr = make_pair(k, int'($urandom % 16));
      end
      apply(pr[2*W-1:W], pr[W-1:0], "R9");
    end
    valid_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired R9 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prefix();
    t_hold();
    t_follow_flush();
    t_long_run();
    t_equal();
    t_random();
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule